// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small 32-bit processor core that finishes every instruction in the clock cycle that fetches it. A program counter addresses a private instruction store, the fetched word is split into fixed fields, and a decoder turns the opcode and function code into datapath selects. Operands come from a 32-entry register file. An ALU with an equality flag works on them, and the result goes back to the register file, to a private data store, or to the next-program-counter logic. It handles word loads and stores, five register-to-register operations (add, subtract, and, or, set-less-than), a branch taken on equality and an absolute jump.

Both stores are word arrays inside the core and are indexed by byte-address bits [MEM_AW+1:2]. A loader port fills them, normally while reset is held. The core has no other output, so every architectural effect is shown on a commit bus: the current PC, the register-file write strobe with its index and data, and the data-store write strobe with its address and data. Reset is synchronous and active high.

The control path has no sequencing states. Each cycle is one pass from fetch to commit, and the only stored control is the PC.

Top module: `sc_risc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 32 registers are cleared. Both write strobes on the commit bus stay low while `rst` is high.
- R2: An instruction that is neither a taken branch nor a jump sets the next PC to PC+4.
- R3: Opcode 0x00 is register-to-register. Funct 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 is bitwise and, 0x25 is bitwise or, and 0x2A gives 1 when rs is less than rt as signed numbers and 0 otherwise. The result goes to the register named by bits 15-11.
- R4: Opcode 0x23 (load word) reads the data store at rs plus the sign-extended bits 15-0 and writes that word to the register named by bits 20-16.
- R5: Opcode 0x2B (store word) writes the rt value to the data store at rs plus the sign-extended bits 15-0 and does not write the register file.
- R6: Opcode 0x04 (branch on equal) writes nothing. If rs equals rt, the next PC is PC+4 plus the sign-extended bits 15-0 shifted left by two. Otherwise it is PC+4.
- R7: Opcode 0x02 (jump) writes nothing and sets the next PC to the top four bits of PC+4, then bits 25-0, then two zero bits.
- R8: Register 0 always reads as zero. A write addressed to it still shows on the commit bus but changes nothing.
- R9: A rising edge with `ld_en` high writes `ld_data` to word `ld_addr` of the data store when `ld_dmem` is 1, and of the instruction store when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Loader write strobe |
| ld_dmem | input | 1 | Loader target: 1 data store, 0 instruction store |
| ld_addr | input | MEM_AW | Loader word index |
| ld_data | input | 32 | Loader word |
| pc_o | output | 32 | Address of the instruction being executed |
| rf_we_o | output | 1 | Register-file write strobe for this instruction |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Value written to the register file |
| dm_we_o | output | 1 | Data-store write strobe for this instruction |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data (rt value) |

## Verification
Every commit-bus signal is a combinational function of the current PC and the stored state, so an instruction's write strobe, index and data are visible during the same cycle that `pc_o` shows its address. Its effect on the PC and on the stores appears one rising edge later. The bench therefore samples one picosecond after each falling edge. At each sample it checks the PC against the address the previous instruction should have produced, and checks the strobes against the instruction at that PC. A value held in a register or in the data store is tested by a later instruction that reads it and puts it on the commit bus.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    typedef enum logic [5:0] {
        OPC_REG   = 6'h00,
        OPC_JMP   = 6'h02,
        OPC_BEQ   = 6'h04,
        OPC_LOAD  = 6'h23,
        OPC_STORE = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_SLT = 6'h2A
    } funct_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2
    } alu_op_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_fn_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    wb_from_mem;
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_fn_e    alu_fn
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = AOP_ADD;
        unique case (opcode)
            OPC_REG: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = AOP_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_write   = 1'b1;
                ctrl.mem_read    = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_is_imm  = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = AOP_SUB;
            end
            OPC_JMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (ctrl.alu_op)
            AOP_ADD: alu_fn = ALU_ADD;
            AOP_SUB: alu_fn = ALU_SUB;
            AOP_FUNCT: begin
                unique case (funct)
                    FN_ADD:  alu_fn = ALU_ADD;
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
            default: alu_fn = ALU_ADD;
        endcase
    end

    // R5: a store never also writes the register file
    assert_store_no_regwrite_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_write |-> !ctrl.reg_write);

    // R6: a branch commits no write anywhere
    assert_branch_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl.branch |-> !(ctrl.reg_write || ctrl.mem_write));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W = 32,
    parameter int N = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [$clog2(N)-1:0] ra1,
    input  logic [$clog2(N)-1:0] ra2,
    output logic [W-1:0]         rd1,
    output logic [W-1:0]         rd2,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

    // R8: a write aimed at register 0 leaves it zero
    assert_r0_stays_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (we && (wa == '0)) |=> (regs[0] == '0));

endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            mem[ld_idx] <= ld_data;
        end else if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_data = rd_en ? mem[idx] : '0;

endmodule

// File: rtl/sc_risc_core.sv
module sc_risc_core
    import sc_core_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    output logic [31:0]       pc_o,
    output logic              rf_we_o,
    output logic [4:0]        rf_waddr_o,
    output logic [31:0]       rf_wdata_o,
    output logic              dm_we_o,
    output logic [31:0]       dm_addr_o,
    output logic [31:0]       dm_wdata_o
);

    localparam int XW     = 32;
    localparam int NREG   = 32;
    localparam int RIDX   = $clog2(NREG);
    localparam int IDX_HI = MEM_AW + 1;

    logic [XW-1:0]   pc_q, pc_d, pc_plus4, br_target, jmp_target;
    logic [XW-1:0]   instr, imm_sx, rs_val, rt_val, alu_b, alu_y, dm_rd, wb_data;
    logic [RIDX-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    logic            alu_zero, take_br, rf_we, dm_we;
    ctrl_t           ctrl;
    alu_fn_e         alu_fn;

    // program counter
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    sc_wordmem #(.W(XW), .AW(MEM_AW)) u_imem (
        .clk     (clk),
        .ld_we   (ld_en && !ld_dmem),
        .ld_idx  (ld_addr),
        .ld_data (ld_data),
        .wr_en   (1'b0),
        .idx     (pc_q[IDX_HI:2]),
        .wr_data ('0),
        .rd_en   (1'b1),
        .rd_data (instr)
    );

    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign imm_sx = {{16{instr[15]}}, instr[15:0]};

    sc_decode u_dec (
        .clk    (clk),
        .rst    (rst),
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    assign wr_idx = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign rf_we  = ctrl.reg_write && !rst;
    assign dm_we  = ctrl.mem_write && !rst;

    sc_regfile #(.W(XW), .N(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (rs_idx),
        .ra2 (rt_idx),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (rf_we),
        .wa  (wr_idx),
        .wd  (wb_data)
    );

    assign alu_b = ctrl.b_is_imm ? imm_sx : rt_val;

    sc_alu #(.W(XW)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    sc_wordmem #(.W(XW), .AW(MEM_AW)) u_dmem (
        .clk     (clk),
        .ld_we   (ld_en && ld_dmem),
        .ld_idx  (ld_addr),
        .ld_data (ld_data),
        .wr_en   (dm_we),
        .idx     (alu_y[IDX_HI:2]),
        .wr_data (rt_val),
        .rd_en   (ctrl.mem_read),
        .rd_data (dm_rd)
    );

    assign wb_data = ctrl.wb_from_mem ? dm_rd : alu_y;

    // next-PC selection
    assign pc_plus4   = pc_q + 32'd4;
    assign br_target  = pc_plus4 + (imm_sx << 2);
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_br    = ctrl.branch && alu_zero;

    always_comb begin
        if (ctrl.jump)   pc_d = jmp_target;
        else if (take_br) pc_d = br_target;
        else             pc_d = pc_plus4;
    end

    assign pc_o       = pc_q;
    assign rf_we_o    = rf_we;
    assign rf_waddr_o = wr_idx;
    assign rf_wdata_o = wb_data;
    assign dm_we_o    = dm_we;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    // R1: reset forces the PC to zero
    assert_reset_pc_zero_R1: assert property (@(posedge clk)
        rst |=> (pc_q == '0));

    // R2: straight-line instructions step the PC by one word
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.branch || ctrl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

    // R6: an unequal compare falls through
    assert_branch_fallthrough_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.branch && !alu_zero) |=> (pc_q == $past(pc_plus4)));

    // R7: a jump keeps the region bits of PC+4 and lands word aligned
    assert_jump_region_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.jump |=> ((pc_q[31:28] == $past(pc_plus4[31:28])) && (pc_q[1:0] == 2'b00)));

endmodule

// File: tb/test_sc_risc_core.sv
`timescale 1ns/1ps
module test_sc_risc_core;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic          ld_dmem = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic          rf_we_o, dm_we_o;
    logic [4:0]    rf_waddr_o;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sc_risc_core #(.MEM_AW(AW)) i_sc_risc_core (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
        .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
        .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {6'h02, 26'(tgt)};
    endfunction

    task automatic load_word(input logic to_dmem, input int idx, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_dmem = to_dmem; ld_addr = AW'(idx); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Compares the commit bus at the current sample point, then moves to the next cycle's sample point
    task automatic expect_cycle(input string req, input logic [31:0] pc,
                                input logic rwe, input int wa, input logic [31:0] wd,
                                input logic mwe, input logic [31:0] ma, input logic [31:0] md);
        logic bad;
        checks++;
        bad = (pc_o !== pc) || (rf_we_o !== rwe) || (dm_we_o !== mwe);
        if (rwe) bad = bad || (rf_waddr_o !== 5'(wa)) || (rf_wdata_o !== wd);
        if (mwe) bad = bad || (dm_addr_o !== ma) || (dm_wdata_o !== md);
        if (bad) begin
            failures++;
            $display("FAIL %s: pc=%h rwe=%b wa=%0d wd=%h mwe=%b ma=%h md=%h expected pc=%h rwe=%b wa=%0d wd=%h mwe=%b ma=%h md=%h",
                     req, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, dm_we_o, dm_addr_o, dm_wdata_o,
                     pc, rwe, wa, wd, mwe, ma, md);
        end
        @(negedge clk); #0.001;
    endtask

    task automatic scen_reset_hold();
        @(negedge clk); #0.001;
        expect_cycle("R1 reset hold", 32'h0, 1'b0, 0, '0, 1'b0, '0, '0);
        expect_cycle("R1 reset hold", 32'h0, 1'b0, 0, '0, 1'b0, '0, '0);
    endtask

    task automatic scen_load();
        // R9: data store words and the program through the loader port
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'd10);
        load_word(1'b0, 0,  enc_r(3, 4, 13, 6'h20));
        load_word(1'b0, 1,  enc_i(6'h23, 0, 1, 0));
        load_word(1'b0, 2,  enc_i(6'h23, 0, 2, 4));
        load_word(1'b0, 3,  enc_r(1, 2, 3, 6'h20));
        load_word(1'b0, 4,  enc_r(1, 2, 4, 6'h22));
        load_word(1'b0, 5,  enc_r(1, 2, 5, 6'h24));
        load_word(1'b0, 6,  enc_r(1, 2, 6, 6'h25));
        load_word(1'b0, 7,  enc_r(4, 1, 7, 6'h2A));
        load_word(1'b0, 8,  enc_r(1, 4, 8, 6'h2A));
        load_word(1'b0, 9,  enc_i(6'h2B, 0, 3, 12));
        load_word(1'b0, 10, enc_i(6'h23, 0, 9, 12));
        load_word(1'b0, 11, enc_r(1, 2, 0, 6'h20));
        load_word(1'b0, 12, enc_r(0, 0, 10, 6'h20));
        load_word(1'b0, 13, enc_r(3, 1, 12, 6'h20));
        load_word(1'b0, 14, enc_i(6'h23, 12, 11, -8));
        load_word(1'b0, 15, enc_i(6'h04, 1, 2, 5));
        load_word(1'b0, 16, enc_i(6'h04, 3, 9, 2));
        load_word(1'b0, 17, enc_r(1, 1, 13, 6'h20));
        load_word(1'b0, 18, enc_j(21));
        load_word(1'b0, 19, enc_i(6'h04, 0, 0, -3));
        load_word(1'b0, 21, enc_j(21));
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
        #0.001;
    endtask

    task automatic scen_alu_mem();
        expect_cycle("R1 cleared regs", 32'd0, 1'b1, 13, 32'd0, 1'b0, '0, '0);
        expect_cycle("R4 load",       32'd4,  1'b1, 1, 32'd5,  1'b0, '0, '0);
        expect_cycle("R4 load",       32'd8,  1'b1, 2, 32'd10, 1'b0, '0, '0);
        expect_cycle("R3 add",        32'd12, 1'b1, 3, 32'd15, 1'b0, '0, '0);
        expect_cycle("R3 sub",        32'd16, 1'b1, 4, 32'hFFFF_FFFB, 1'b0, '0, '0);
        expect_cycle("R3 and",        32'd20, 1'b1, 5, 32'd0,  1'b0, '0, '0);
        expect_cycle("R3 or",         32'd24, 1'b1, 6, 32'd15, 1'b0, '0, '0);
        expect_cycle("R3 slt true",   32'd28, 1'b1, 7, 32'd1,  1'b0, '0, '0);
        expect_cycle("R3 slt false",  32'd32, 1'b1, 8, 32'd0,  1'b0, '0, '0);
        expect_cycle("R5 store",      32'd36, 1'b0, 0, '0, 1'b1, 32'd12, 32'd15);
        expect_cycle("R5 readback",   32'd40, 1'b1, 9, 32'd15, 1'b0, '0, '0);
    endtask

    task automatic scen_zero_reg();
        expect_cycle("R8 write r0",   32'd44, 1'b1, 0, 32'd15, 1'b0, '0, '0);
        expect_cycle("R8 read r0",    32'd48, 1'b1, 10, 32'd0, 1'b0, '0, '0);
        expect_cycle("R2 add base",   32'd52, 1'b1, 12, 32'd20, 1'b0, '0, '0);
        expect_cycle("R4 neg offset", 32'd56, 1'b1, 11, 32'd15, 1'b0, '0, '0);
    endtask

    task automatic scen_flow();
        expect_cycle("R6 not taken",  32'd60, 1'b0, 0, '0, 1'b0, '0, '0);
        expect_cycle("R6 taken fwd",  32'd64, 1'b0, 0, '0, 1'b0, '0, '0);
        expect_cycle("R6 taken back", 32'd76, 1'b0, 0, '0, 1'b0, '0, '0);
        expect_cycle("R6 target",     32'd68, 1'b1, 13, 32'd10, 1'b0, '0, '0);
        expect_cycle("R7 jump",       32'd72, 1'b0, 0, '0, 1'b0, '0, '0);
        expect_cycle("R7 self jump",  32'd84, 1'b0, 0, '0, 1'b0, '0, '0);
        expect_cycle("R7 held",       32'd84, 1'b0, 0, '0, 1'b0, '0, '0);
    endtask

    task automatic scen_rereset();
        // R1: registers hold non-zero values here; a second reset must clear them
        rst = 1'b1;
        @(negedge clk); #0.001;
        expect_cycle("R1 re-reset",   32'd0, 1'b0, 0, '0, 1'b0, '0, '0);
        release_reset();
        expect_cycle("R1 regs cleared", 32'd0, 1'b1, 13, 32'd0, 1'b0, '0, '0);
        expect_cycle("R4 reload",     32'd4, 1'b1, 1, 32'd5, 1'b0, '0, '0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(20000 * 5);
        failures++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        scen_reset_hold();
        scen_load();
        release_reset();
        scen_alu_mem();
        scen_zero_reg();
        scen_flow();
        scen_rereset();
        finish_run();
    end

endmodule